// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses where the two ALU operands of a five-stage in-order integer pipeline come from. The stages are fetch, decode, execute, memory and writeback. Each source register named by the instruction in execute is compared with the destination and write enable of the instructions in the memory and writeback stages. From those matches the block drives one 2-bit multiplexer select per operand. A dependent instruction therefore picks up a result from the pipeline registers and does not wait for that result to be written back.

The block also gives the register file write-through behaviour. When decode reads a register in the same cycle that writeback writes it, the decode read data is replaced by the value being written.

The memory stage carries a flag that marks a load. A load in the memory stage has no data yet at the point where forwarding happens, so it is never used as a forwarding source. The stall logic outside this block must keep the dependent instruction out of execute until the load has moved on. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When an execute source register equals the memory-stage destination, the memory-stage write enable is 1, the memory-stage load flag is 0, and the register is not 0, that operand's select is 2'b10 (memory-stage result).
- R2: When an execute source register equals the writeback-stage destination, the writeback write enable is 1, the register is not 0, and R1 does not apply, that operand's select is 2'b01 (writeback-stage result).
- R3: When both the memory stage and the writeback stage qualify for the same source register, the select is 2'b10. The memory stage always wins.
- R4: A source register number of 0 always gives select 2'b00 (register file), even if a later stage names register 0 as its destination with write enable set.
- R5: A stage whose write enable is 0 never causes a forward, whatever its destination register is.
- R6: With no qualifying match, the select is 2'b00. The select never takes the value 2'b11.
- R7: When the memory-stage load flag is 1 and its destination matches a nonzero source register with write enable set, that operand's select is 2'b00. This holds even when writeback also matches, because the writeback value is older than the load's result.
- R8: A decode read port returns the writeback data instead of the register-file data when its register equals the writeback destination, the writeback write enable is 1, and the register is not 0. Otherwise it returns the register-file data unchanged.
- R9: The two operands are resolved independently. Each select and each decode port depends only on its own source register and the shared stage information.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register of the execute-stage instruction |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_data | input | XLEN | Value being written back this cycle |
| id_src_a | input | 5 | First decode-stage read register |
| id_src_b | input | 5 | Second decode-stage read register |
| rf_data_a | input | XLEN | Register-file output for id_src_a |
| rf_data_b | input | XLEN | Register-file output for id_src_b |
| sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Operand B select, same encoding |
| id_data_a | output | XLEN | Decode read data A after write-through |
| id_data_b | output | XLEN | Decode read data B after write-through |

## Verification
The block holds no state, so any fault in a comparator or in the priority logic appears on sel_a, sel_b or the decode data in the same cycle as the input pattern that exposes it. The hard cases are patterns where the correct answer depends on which match gets suppressed: a dual match, a load in the memory stage sitting on top of a valid writeback match, a disabled writer, and register 0. Back-to-back dependent instruction sequences walk every distance between producer and consumer, so a swapped priority or a missing qualifier changes a select within one instruction of the dependency.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int unsigned REG_AW = 5;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } opsel_e;

    typedef struct packed {
        logic [REG_AW-1:0] dst;
        logic              wen;
        logic              load;
    } stage_wr_t;

    function automatic logic writes_reg(input stage_wr_t w, input logic [REG_AW-1:0] r);
        return w.wen && (w.dst == r) && (r != '0);
    endfunction

endpackage

// File: rtl/fwd_opsel.sv
module fwd_opsel
    import fwd_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  stage_wr_t         mem_w,
    input  stage_wr_t         wb_w,
    output opsel_e            sel
);

    logic mem_hit;
    logic wb_hit;

    assign mem_hit = writes_reg(mem_w, src);
    assign wb_hit  = writes_reg(wb_w, src);

    always_comb begin
        if (mem_hit) begin
            sel = mem_w.load ? SEL_RF : SEL_MEM;
        end else if (wb_hit) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_RF;
        end
    end

    always_comb begin
        if (!$isunknown({src, mem_w, wb_w})) begin
            // R4
            zero_src_chk: assert (src != '0 || sel == SEL_RF);
            // R6
            legal_sel_chk: assert (sel != 2'b11);
            // R7
            load_block_chk: assert (!(mem_w.load && mem_w.wen && mem_w.dst == src) || sel != SEL_MEM);
            // R5
            wen_gate_chk: assert ((sel != SEL_MEM || mem_w.wen) && (sel != SEL_WB || wb_w.wen));
            // R3
            mem_prio_chk: assert (!(sel == SEL_WB && mem_w.wen && mem_w.dst == src));
        end
    end

endmodule

// File: rtl/fwd_rd_bypass.sv
module fwd_rd_bypass
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [REG_AW-1:0] src,
    input  logic [XLEN-1:0]   rf_data,
    input  stage_wr_t         wb_w,
    input  logic [XLEN-1:0]   wb_data,
    output logic [XLEN-1:0]   rd_data
);

    logic thru;

    assign thru    = writes_reg(wb_w, src);
    assign rd_data = thru ? wb_data : rf_data;

    always_comb begin
        if (!$isunknown({src, wb_w, rf_data, wb_data})) begin
            // R8
            write_through_chk: assert (!(wb_w.wen && wb_w.dst == src && src != '0) || rd_data == wb_data);
            // R8
            plain_read_chk: assert ((wb_w.wen && wb_w.dst == src && src != '0) || rd_data == rf_data);
        end
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    localparam int unsigned NOPS = 2
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wen,
    input  logic [XLEN-1:0]   wb_data,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic [XLEN-1:0]   rf_data_a,
    input  logic [XLEN-1:0]   rf_data_b,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [XLEN-1:0]   id_data_a,
    output logic [XLEN-1:0]   id_data_b
);

    stage_wr_t mem_w;
    stage_wr_t wb_w;

    assign mem_w = '{dst: mem_dst, wen: mem_wen, load: mem_load};
    assign wb_w  = '{dst: wb_dst,  wen: wb_wen,  load: 1'b0};

    logic [REG_AW-1:0] ex_src [NOPS];
    logic [REG_AW-1:0] id_src [NOPS];
    logic [XLEN-1:0]   rf_dat [NOPS];
    logic [XLEN-1:0]   id_dat [NOPS];
    opsel_e            sel    [NOPS];

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;
    assign id_src[0] = id_src_a;
    assign id_src[1] = id_src_b;
    assign rf_dat[0] = rf_data_a;
    assign rf_dat[1] = rf_data_b;

    // R9: one independent selector and bypass per operand
    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fwd_opsel u_sel (
            .src   (ex_src[i]),
            .mem_w (mem_w),
            .wb_w  (wb_w),
            .sel   (sel[i])
        );
        fwd_rd_bypass #(.XLEN(XLEN)) u_byp (
            .src     (id_src[i]),
            .rf_data (rf_dat[i]),
            .wb_w    (wb_w),
            .wb_data (wb_data),
            .rd_data (id_dat[i])
        );
    end

    assign sel_a     = sel[0];
    assign sel_b     = sel[1];
    assign id_data_a = id_dat[0];
    assign id_data_b = id_dat[1];

endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

    localparam int XLEN = 32;

    typedef struct {
        logic [1:0]      sa;
        logic [1:0]      sb;
        logic [XLEN-1:0] da;
        logic [XLEN-1:0] db;
        string           tag;
    } exp_t;

    typedef struct {
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       we;
        logic       ld;
    } ins_t;

    logic clk = 0;
    logic rst = 1;
    always #10 clk = ~clk;

    logic [4:0]      ex_src_a, ex_src_b, mem_dst, wb_dst, id_src_a, id_src_b;
    logic            mem_wen, mem_load, wb_wen;
    logic [XLEN-1:0] wb_data, rf_data_a, rf_data_b, id_data_a, id_data_b;
    logic [1:0]      sel_a, sel_b;

    fwd_unit #(.XLEN(XLEN)) u_fwd_unit (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_data(wb_data),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .sel_a(sel_a), .sel_b(sel_b),
        .id_data_a(id_data_a), .id_data_b(id_data_b)
    );

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference from the requirement text (R1-style priority, R4 zero, R5 enable, R7 load)
    function automatic logic [1:0] ref_sel(input logic [4:0] s);
        if (s != 0 && mem_wen && mem_dst == s) return mem_load ? 2'b00 : 2'b10;
        if (s != 0 && wb_wen && wb_dst == s)   return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [XLEN-1:0] ref_rd(input logic [4:0] s, input logic [XLEN-1:0] rf);
        return (s != 0 && wb_wen && wb_dst == s) ? wb_data : rf;
    endfunction

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] md, input logic mw, input logic ml,
                         input logic [4:0] wd, input logic ww,
                         input logic [4:0] ia, input logic [4:0] ib, input string tag);
        exp_t e;
        @(negedge clk);
        ex_src_a = a;  ex_src_b = b;
        mem_dst = md;  mem_wen = mw;  mem_load = ml;
        wb_dst = wd;   wb_wen = ww;
        wb_data   = 32'hB000_0000 | {27'd0, wd} | (n_run << 8);
        id_src_a  = ia; id_src_b = ib;
        rf_data_a = 32'hA000_0000 | {27'd0, ia};
        rf_data_b = 32'hC000_0000 | {27'd0, ib};
        e.sa = ref_sel(a); e.sb = ref_sel(b);
        e.da = ref_rd(ia, rf_data_a); e.db = ref_rd(ib, rf_data_b);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one item per cycle, samples mid-high phase
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "sel_a", {30'd0, sel_a}, {30'd0, e.sa});
                cmp(e.tag, "sel_b", {30'd0, sel_b}, {30'd0, e.sb});
                cmp(e.tag, "id_data_a", id_data_a, e.da);
                cmp(e.tag, "id_data_b", id_data_b, e.db);
            end
        end
    end

    ins_t prog [12];

    initial begin
        // Quiet state: everything selects the register file (R6)
        ex_src_a = 0; ex_src_b = 0; mem_dst = 0; mem_wen = 0; mem_load = 0;
        wb_dst = 0; wb_wen = 0; wb_data = 0; id_src_a = 0; id_src_b = 0;
        rf_data_a = 0; rf_data_b = 0;
        repeat (2) @(posedge clk);
        rst = 0;
        drive(5'd3, 5'd4, 5'd7, 1, 0, 5'd8, 1, 5'd9, 5'd10, "R6 no match");
        drive(5'd7, 5'd4, 5'd7, 1, 0, 5'd8, 1, 5'd1, 5'd2,  "R1 mem match a");
        drive(5'd4, 5'd8, 5'd7, 1, 0, 5'd8, 1, 5'd1, 5'd2,  "R2 wb match b");
        drive(5'd9, 5'd9, 5'd9, 1, 0, 5'd9, 1, 5'd3, 5'd3,  "R3 dual match");
        drive(5'd0, 5'd0, 5'd0, 1, 0, 5'd0, 1, 5'd0, 5'd0,  "R4 zero reg");
        drive(5'd6, 5'd5, 5'd6, 0, 0, 5'd5, 0, 5'd5, 5'd6,  "R5 wen low");
        drive(5'd11, 5'd12, 5'd11, 1, 1, 5'd11, 1, 5'd1, 5'd1, "R7 load over wb");
        drive(5'd12, 5'd13, 5'd12, 1, 1, 5'd13, 1, 5'd4, 5'd4, "R7 load a, R2 b");
        drive(5'd1, 5'd2, 5'd3, 1, 0, 5'd20, 1, 5'd20, 5'd21, "R8 write-through a");
        drive(5'd1, 5'd2, 5'd3, 1, 0, 5'd21, 0, 5'd21, 5'd21, "R8 wen low no bypass");
        drive(5'd2, 5'd31, 5'd31, 1, 0, 5'd2, 1, 5'd31, 5'd2, "R9 split a wb b mem");
        // Back-to-back dependent sequence through a modelled pipeline (R1 R2 R3 R7)
        prog[0]  = '{5'd1, 5'd0, 5'd0, 1, 0};
        prog[1]  = '{5'd2, 5'd1, 5'd0, 1, 0};
        prog[2]  = '{5'd3, 5'd1, 5'd2, 1, 0};
        prog[3]  = '{5'd1, 5'd2, 5'd3, 1, 1};
        prog[4]  = '{5'd4, 5'd5, 5'd6, 1, 0};
        prog[5]  = '{5'd4, 5'd1, 5'd4, 1, 0};
        prog[6]  = '{5'd0, 5'd4, 5'd4, 1, 0};
        prog[7]  = '{5'd5, 5'd0, 5'd4, 0, 0};
        prog[8]  = '{5'd6, 5'd5, 5'd0, 1, 0};
        prog[9]  = '{5'd7, 5'd6, 5'd6, 1, 1};
        prog[10] = '{5'd8, 5'd6, 5'd7, 1, 0};
        prog[11] = '{5'd9, 5'd7, 5'd8, 1, 0};
        for (int k = 2; k < 11; k++) begin
            drive(prog[k].rs1, prog[k].rs2,
                  prog[k-1].rd, prog[k-1].we, prog[k-1].ld,
                  prog[k-2].rd, prog[k-2].we,
                  prog[k+1].rs1, prog[k+1].rs2, "R1 R2 R3 R7 R8 sequence");
        end
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule